// File: doc/BRIEF.md
# Matrix Run Completion Timer

This block decides when one matrix-multiply pass through a row-partitioned, weight-stationary array has finished, so that the array can stop early instead of always waiting for the worst case. The array is split into equal groups of rows. In dense mode the groups are chained, and each boundary stage between groups adds one register cycle. In sparse mode every group works on its own and drains into its own buffer.

On a start pulse the block reads the number of input rows to stream, the column count of the condensed weight tile, and the mode bit. From these values and its array parameters it computes the number of cycles the pass needs. It then raises busy and counts cycles until that target is reached. When the target is reached it emits a one-cycle done pulse, and busy falls on the same cycle. The target is the sum of three parts: the streamed rows, the skew of the last weight column and the last active row, and the traversal latency of a partial sum.

Top module: `early_term_ctrl`

## Requirements
- R1: After reset, busy and done are both 0 until a start is accepted.
- R2: In dense mode (mode bit 0) with M input rows and W condensed columns, both nonzero, busy stays high for exactly M + W + 2*ROWS_TOTAL + 2*GROUPS - 4 cycles.
- R3: In sparse mode (mode bit 1) with M and W both nonzero, busy stays high for exactly M + W + 2*(ROWS_TOTAL/GROUPS) - 1 cycles.
- R4: A start sampled while busy is low raises busy in the next cycle.
- R5: Done is high for exactly one cycle. That cycle is the first cycle in which busy is low after a run, and done is never high while busy is high.
- R6: A start sampled while busy is high is ignored, together with the dimensions and mode presented with it. The run ends at its original time.
- R7: If M or W is zero, the run lasts exactly one busy cycle.
- R8: Mode and dimension inputs are sampled only with an accepted start. Changing them during a run has no effect on its length.
- R9: The internal cycle count never exceeds the loaded target while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a run |
| sparse_mode | input | 1 | 1 = independent groups, 0 = chained groups |
| in_rows | input | DIM_W | Number of input rows streamed |
| wt_cols | input | DIM_W | Columns in the condensed weight tile |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are a second start, or a change of mode and dimensions, that arrives in the middle of a run. Neither may shift the completion point. The stimulus raises start with different operands, or only swaps the operands, a couple of cycles into a long run. It then measures the exact busy length against the value computed from the original operands. Zero-dimension runs and the largest dimension values test the edges of the target arithmetic.

// File: rtl/early_term_pkg.sv
package early_term_pkg;
   typedef enum logic {
      MODE_CHAINED     = 1'b0,
      MODE_INDEPENDENT = 1'b1
   } run_mode_e;

   function automatic int unsigned dense_fixed(int unsigned rows, int unsigned groups);
      return 2 * rows + 2 * groups - 4;
   endfunction

   function automatic int unsigned sparse_fixed(int unsigned rows, int unsigned groups);
      return 2 * (rows / groups) - 1;
   endfunction
endpackage

// File: rtl/early_term_target.sv
module early_term_target
   import early_term_pkg::*;
#(
   parameter int unsigned ROWS_TOTAL = 16,
   parameter int unsigned GROUPS     = 4,
   parameter int unsigned DIM_W      = 8,
   parameter int unsigned CNT_W      = 14
) (
   input  logic             sparse_mode,
   input  logic [DIM_W-1:0] in_rows,
   input  logic [DIM_W-1:0] wt_cols,
   output logic [CNT_W-1:0] target
);
   localparam int unsigned DENSE_FIX  = dense_fixed(ROWS_TOTAL, GROUPS);
   localparam int unsigned SPARSE_FIX = sparse_fixed(ROWS_TOTAL, GROUPS);

   logic [CNT_W-1:0] fixed_part;
   logic             empty_run;

   generate
      if (GROUPS == 1) begin : g_single
         logic unused_mode;
         assign unused_mode = sparse_mode;
         assign fixed_part  = CNT_W'(DENSE_FIX);
      end else begin : g_split
         assign fixed_part = (run_mode_e'(sparse_mode) == MODE_INDEPENDENT)
                             ? CNT_W'(SPARSE_FIX) : CNT_W'(DENSE_FIX);
      end
   endgenerate

   assign empty_run = (in_rows == '0) || (wt_cols == '0);

   always_comb begin
      if (empty_run)
         target = CNT_W'(1);
      else
         target = CNT_W'(in_rows) + CNT_W'(wt_cols) + fixed_part;
   end
endmodule

// File: rtl/early_term_counter.sv
module early_term_counter #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] target_in,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] target_q
);
   logic reached;

   assign reached = (cnt_q == target_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         cnt_q    <= '0;
         target_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy     <= 1'b1;
               cnt_q    <= CNT_W'(1);
               target_q <= target_in;
            end
         end else if (reached) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/early_term_ctrl.sv
module early_term_ctrl #(
   parameter int unsigned ROWS_TOTAL = 16,
   parameter int unsigned GROUPS     = 4,
   parameter int unsigned DIM_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sparse_mode,
   input  logic [DIM_W-1:0] in_rows,
   input  logic [DIM_W-1:0] wt_cols,
   output logic             busy,
   output logic             done
);
   localparam int unsigned CNT_W = DIM_W + $clog2(2 * ROWS_TOTAL + 2 * GROUPS) + 1;

   generate
      if (GROUPS < 1 || ROWS_TOTAL < GROUPS || (ROWS_TOTAL % GROUPS) != 0) begin : g_bad_geom
         $error("ROWS_TOTAL must be a nonzero multiple of GROUPS");
      end
      if (DIM_W < 1) begin : g_bad_width
         $error("DIM_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] target_w;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target_q;

   early_term_target #(
      .ROWS_TOTAL(ROWS_TOTAL),
      .GROUPS    (GROUPS),
      .DIM_W     (DIM_W),
      .CNT_W     (CNT_W)
   ) u_target (
      .sparse_mode(sparse_mode),
      .in_rows    (in_rows),
      .wt_cols    (wt_cols),
      .target     (target_w)
   );

   early_term_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .target_in(target_w),
      .busy     (busy),
      .done     (done),
      .cnt_q    (cnt_q),
      .target_q (target_q)
   );
endmodule

// File: rtl/early_term_ctrl_chk.sv
module early_term_ctrl_chk #(
   parameter int unsigned CNT_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] target_q
);
   assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_follows_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= target_q));

   assert_ignore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(target_q));
endmodule

bind early_term_ctrl early_term_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .cnt_q   (cnt_q),
   .target_q(target_q)
);

// File: tb/early_term_ctrl_tb.sv
module early_term_ctrl_tb;
   localparam int unsigned ROWS_TOTAL = 16;
   localparam int unsigned GROUPS     = 4;
   localparam int unsigned DIM_W      = 8;
   localparam int unsigned GROUP_ROWS = ROWS_TOTAL / GROUPS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             sparse_mode = 1'b0;
   logic [DIM_W-1:0] in_rows = '0;
   logic [DIM_W-1:0] wt_cols = '0;
   logic             busy;
   logic             done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   early_term_ctrl #(
      .ROWS_TOTAL(ROWS_TOTAL),
      .GROUPS    (GROUPS),
      .DIM_W     (DIM_W)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .sparse_mode(sparse_mode),
      .in_rows    (in_rows),
      .wt_cols    (wt_cols),
      .busy       (busy),
      .done       (done)
   );

   task automatic check(input bit ok, input string req, input int actual, input int expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   function automatic int exp_len(input bit sp, input int m, input int w);
      if (m == 0 || w == 0) return 1;
      if (sp) return m + w + 2 * GROUP_ROWS - 1;
      return m + w + 2 * ROWS_TOTAL + 2 * GROUPS - 4;
   endfunction

   // disturb: 0 none, 1 second start with other operands, 2 operands change only
   task automatic run_case(input string req, input bit sp, input int m, input int w,
                           input int disturb);
      int n;
      int expected;
      int done_in_busy;
      expected = exp_len(sp, m, w);
      @(negedge clk);
      sparse_mode = sp;
      in_rows     = DIM_W'(m);
      wt_cols     = DIM_W'(w);
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R4 busy after start", int'(busy), 1);
      n = 0;
      done_in_busy = 0;
      while (busy && n < 5000) begin
         n++;
         if (done) done_in_busy++;
         if (n == 2 && disturb == 1) begin
            start       = 1'b1;
            sparse_mode = ~sp;
            in_rows     = 8'd1;
            wt_cols     = 8'd1;
         end
         if (n == 2 && disturb == 2) begin
            sparse_mode = ~sp;
            in_rows     = 8'd250;
            wt_cols     = 8'd0;
         end
         @(negedge clk);
         start = 1'b0;
      end
      check(n == expected, req, n, expected);
      check(done_in_busy == 0, "R5 done while busy", done_in_busy, 0);
      check(done == 1'b1, "R5 done on busy fall", int'(done), 1);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R5 done single pulse", int'(done), 0);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'(busy), 0);
   endtask

   initial begin
      test_reset();
      run_case("R2 dense small",        1'b0, 3,   5,   0);
      run_case("R2 dense max",          1'b0, 255, 255, 0);
      run_case("R3 sparse minimal",     1'b1, 1,   1,   0);
      run_case("R3 sparse typical",     1'b1, 10,  2,   0);
      run_case("R7 zero rows dense",    1'b0, 0,   9,   0);
      run_case("R7 zero cols sparse",   1'b1, 7,   0,   0);
      run_case("R6 start while busy",   1'b0, 4,   4,   1);
      run_case("R6 start while busy sp",1'b1, 20,  3,   1);
      run_case("R8 operands change",    1'b1, 6,   6,   2);
      run_case("R8 operands change dn", 1'b0, 2,   30,  2);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule